// File: doc/BRIEF.md
# Parallel Converter Start and Result Latch Controller

This block is the digital front end of a 12-bit converter with a parallel output. A host starts a conversion by pulling both the active-low select and the active-low read strobe low. The block then holds its active-low busy flag low for a fixed number of converter-clock half periods. At the end it moves a new result word into an output latch. The latch drives a three-state data bus, which is enabled only while both strobes are low. The comparator and the bit search are not modelled here: the result is the sample word that was present when the conversion began.

The block runs on a system clock at twice the converter-clock rate. The converter clock is a level input toggled by logic on that system clock. This makes half-cycle conversion lengths a plain count of system cycles. The strobes and the converter clock pass through the same two-flop synchronizer. Their relative timing at the pins is therefore kept, and the block can tell whether read fell together with a converter-clock falling edge.

The interface has no valid/ready handshake and no back-pressure. The sample word is read in a single cycle when the conversion starts. The result stays in the latch until the next conversion ends.

Top module: `adc_conv_ctrl`

## Requirements
- R1: A conversion starts only when `cs_n` and `rd_n` are both sampled low. `busy_n` goes low two system-clock rising edges after the first rising edge at which both are sampled low.
- R2: A new start needs the pair to leave the both-low state and enter it again. Entries while a conversion runs are ignored and neither lengthen nor restart it. A both-low level held past the end of a conversion does not start another one.
- R3: `busy_n` is high while idle, stays low for the whole conversion and returns high when it ends.
- R4: The conversion lasts 25 system cycles (12.5 converter-clock cycles) when `conv_clk` did not fall together with the strobes.
- R5: The conversion lasts 26 system cycles (13 converter-clock cycles) when, at the first rising edge where both strobes are sampled low, `conv_clk` is sampled low after being sampled high at the previous edge.
- R6: While a conversion runs, the output latch keeps the previous result. A read made during the conversion shows that previous result.
- R7: The latch takes the `sample_in` word held at the start edge. It loads on the same rising edge on which `busy_n` returns high. Later changes of `sample_in` have no effect on that result.
- R8: `data_oe` is high and `data_bus` carries the latch as one parallel word exactly while both `cs_n` and `rd_n` are low at the pins. This path is combinational and not synchronized. Otherwise the bus is released to high impedance.
- R9: After reset the latch holds zero and `busy_n` is high.
- R10: Only one of the two strobes low never starts a conversion and never enables the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, twice the converter-clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| conv_clk | input | 1 | Converter clock level, toggles once per system cycle |
| sample_in | input | 12 | Word used as the conversion result |
| busy_n | output | 1 | Low while a conversion runs |
| data_bus | output | 12 | Three-state result bus |
| data_oe | output | 1 | High while the data bus is driven |

## Verification
Two situations are hard to reach from the ports. The first is the 13-cycle case, where read must fall in exactly the system cycle in which the converter clock falls. The second is a second start that lands inside a running conversion. The bench generates the converter clock itself, so it knows its phase. It waits for the chosen phase before dropping the strobes, which lets it pick either length on demand. The retrigger is produced by releasing and re-asserting the strobes at fixed cycles within the conversion window, with a different sample word each time. The bench then checks that the total busy time and the delivered result both come from the first start.

// File: rtl/adcc_pkg.sv
package adcc_pkg;
  localparam int unsigned ADCC_DATA_W     = 12;
  localparam int unsigned ADCC_SYNC_DEPTH = 2;
  localparam int unsigned ADCC_HALF_SHORT = 25;
  localparam int unsigned ADCC_HALF_LONG  = 26;

  // positions inside the synchronized control vector
  typedef struct packed {
    logic cclk;
    logic cs_n;
    logic rd_n;
  } adcc_ctl_t;
endpackage

// File: rtl/adcc_sync.sv
module adcc_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= RST_VAL;
        else        stg_q <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= {STAGES{RST_VAL}};
        else        stg_q <= {stg_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/adcc_timer.sv
module adcc_timer #(
  parameter int unsigned HALF_SHORT = 25,
  parameter int unsigned HALF_LONG  = 26,
  localparam int unsigned CNT_W = $clog2(HALF_LONG + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic both_low,   // synchronized select-and-read condition
  input  logic cclk_s,     // synchronized converter clock
  output logic start_ok,   // accepted start, one cycle
  output logic running,
  output logic done        // last cycle of a conversion
);
  localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(HALF_SHORT - 1);
  localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(HALF_LONG - 1);

  logic             both_low_q;
  logic             cclk_q;
  logic             start_edge;
  logic             fall_ph;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      both_low_q <= 1'b0;
      cclk_q     <= 1'b0;
    end else begin
      both_low_q <= both_low;
      cclk_q     <= cclk_s;
    end
  end

  assign start_edge = both_low & ~both_low_q;
  assign fall_ph    = cclk_q & ~cclk_s;
  assign start_ok   = start_edge & ~running;
  assign done       = running & (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      cnt_q   <= '0;
    end else if (start_ok) begin
      running <= 1'b1;
      cnt_q   <= fall_ph ? LAST_LONG : LAST_SHORT;
    end else if (running) begin
      if (cnt_q == '0) running <= 1'b0;
      else             cnt_q   <= cnt_q - 1'b1;
    end
  end

  // R2: a running conversion keeps counting down, a new start does not reload it
  a_r2_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (running && cnt_q != '0) |=> (running && cnt_q == $past(cnt_q) - 1'b1));

  // R4 / R5: the first count matches the converter-clock phase at the start
  a_r4_r5_length: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> (cnt_q == ($past(fall_ph) ? LAST_LONG : LAST_SHORT)));
endmodule

// File: rtl/adcc_latch.sv
module adcc_latch #(
  parameter int unsigned DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic              load,
  input  logic [DATA_W-1:0] sample,
  output logic [DATA_W-1:0] result
);
  logic [DATA_W-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      result <= '0;
    end else begin
      if (capture) hold_q <= sample;
      if (load)    result <= hold_q;
    end
  end

  // R6: without a load the latch keeps its value
  a_r6_hold_prev: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(result));

  // R7: a load moves the word captured at the start
  a_r7_load_word: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (result == $past(hold_q)));
endmodule

// File: rtl/adc_conv_ctrl.sv
module adc_conv_ctrl
  import adcc_pkg::*;
#(
  parameter int unsigned DATA_W      = ADCC_DATA_W,
  parameter int unsigned SYNC_STAGES = ADCC_SYNC_DEPTH,
  parameter int unsigned HALF_SHORT  = ADCC_HALF_SHORT,
  parameter int unsigned HALF_LONG   = ADCC_HALF_LONG
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              conv_clk,
  input  logic [DATA_W-1:0] sample_in,
  output logic              busy_n,
  output logic [DATA_W-1:0] data_bus,
  output logic              data_oe
);
  localparam int unsigned CTL_W = $bits(adcc_ctl_t);

  adcc_ctl_t         ctl_raw;
  adcc_ctl_t         ctl_s;
  logic              start_ok;
  logic              running;
  logic              done;
  logic [DATA_W-1:0] result;

  assign ctl_raw = '{cclk: conv_clk, cs_n: cs_n, rd_n: rd_n};

  adcc_sync #(
    .WIDTH  (CTL_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(CTL_W'(3'b011))
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (ctl_raw),
    .q    (ctl_s)
  );

  adcc_timer #(
    .HALF_SHORT(HALF_SHORT),
    .HALF_LONG (HALF_LONG)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .both_low(~ctl_s.cs_n & ~ctl_s.rd_n),
    .cclk_s  (ctl_s.cclk),
    .start_ok(start_ok),
    .running (running),
    .done    (done)
  );

  adcc_latch #(
    .DATA_W(DATA_W)
  ) u_latch (
    .clk    (clk),
    .rst_n  (rst_n),
    .capture(start_ok),
    .load   (done),
    .sample (sample_in),
    .result (result)
  );

  assign busy_n   = ~running;
  assign data_oe  = ~cs_n & ~rd_n;
  assign data_bus = data_oe ? result : {DATA_W{1'bz}};

  // R1: busy only falls after both synchronized strobes were low
  a_r1_both_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_n) |-> $past(!ctl_s.cs_n && !ctl_s.rd_n));

  // R3: busy returns high only at the end of a counted conversion
  a_r3_busy_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_n) |-> $past(done));
endmodule

// File: tb/adc_conv_ctrl_tb.sv
module adc_conv_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        rd_n = 1'b1;
  logic        conv_clk = 1'b0;
  logic [11:0] sample_in = '0;
  logic        busy_n;
  wire  [11:0] data_bus;
  logic        data_oe;

  int n_cmp = 0;
  int n_bad = 0;

  // {long phase, sample word}
  localparam logic [12:0] VEC [6] = '{
    {1'b0, 12'hA5C}, {1'b1, 12'h3F1}, {1'b0, 12'hFFF},
    {1'b1, 12'h000}, {1'b1, 12'h801}, {1'b0, 12'h7FE}
  };

  adc_conv_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n),
    .conv_clk(conv_clk), .sample_in(sample_in), .busy_n(busy_n),
    .data_bus(data_bus), .data_oe(data_oe)
  );

  always #10 clk = ~clk;
  always @(negedge clk) conv_clk <= ~conv_clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // returns at a negedge; long=1 means conv_clk falls at this negedge
  task automatic align(input bit lng);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (conv_clk == lng) break;
    end
  endtask

  task automatic conversion(input bit lng, input logic [11:0] smp, input logic [11:0] prev);
    int n;
    align(lng);
    cs_n <= 1'b0; rd_n <= 1'b0; sample_in <= smp;
    @(negedge clk); chk(busy_n == 1'b1, "R1 latency edge1", busy_n, 1);
    @(negedge clk); chk(busy_n == 1'b1, "R1 latency edge2", busy_n, 1);
    @(negedge clk); chk(busy_n == 1'b0, "R1/R3 busy low", busy_n, 0);
    chk(data_oe && data_bus == prev, "R6 previous result", data_bus, prev);
    sample_in <= ~smp;
    n = 1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (busy_n) break;
      n++;
    end
    if (lng) chk(n == 26, "R5 long length", n, 26);
    else     chk(n == 25, "R4 short length", n, 25);
    chk(data_bus == smp, "R7 new result", data_bus, smp);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(busy_n == 1'b1, "R2 held low no restart", busy_n, 1);
    end
    cs_n <= 1'b1; rd_n <= 1'b1;
    @(negedge clk); chk(data_oe == 1'b0, "R8 bus released", data_oe, 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    report();
  end

  initial begin
    logic [11:0] prev;
    int n;
    repeat (3) @(negedge clk);
    rst_n <= 1'b1;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(busy_n == 1'b1, "R9 busy after reset", busy_n, 1);
    chk(data_oe == 1'b0, "R9 bus off after reset", data_oe, 0);

    prev = 12'h000;
    foreach (VEC[i]) begin
      conversion(VEC[i][12], VEC[i][11:0], prev); // R9 first prev is zero
      prev = VEC[i][11:0];
    end

    // R10: one strobe low alone
    rd_n <= 1'b0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk(busy_n == 1'b1 && data_oe == 1'b0, "R10 read alone", {busy_n, data_oe}, 2);
    end
    rd_n <= 1'b1;
    @(negedge clk);
    cs_n <= 1'b0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk(busy_n == 1'b1 && data_oe == 1'b0, "R10 select alone", {busy_n, data_oe}, 2);
    end
    cs_n <= 1'b1;
    repeat (4) @(negedge clk);

    // R2 retrigger in short reads (read-only-memory style access)
    align(1'b0);
    cs_n <= 1'b0; rd_n <= 1'b0; sample_in <= 12'h5A5;
    n = 0;
    for (int c = 1; c <= 60; c++) begin
      @(negedge clk);
      if (!busy_n) n++;
      if (c == 3) chk(data_bus == prev, "R6 read during conversion", data_bus, prev);
      if (c == 4) begin cs_n <= 1'b1; rd_n <= 1'b1; end
      if (c == 5) chk(data_oe == 1'b0, "R8 released mid conversion", data_oe, 0);
      if (c == 8) begin cs_n <= 1'b0; rd_n <= 1'b0; sample_in <= 12'h0F0; end
      if (c == 12) begin cs_n <= 1'b1; rd_n <= 1'b1; end
    end
    chk(n == 25, "R2 retrigger ignored length", n, 25);
    cs_n <= 1'b0; rd_n <= 1'b0;
    #1;
    chk(data_oe == 1'b1 && data_bus == 12'h5A5, "R2/R8 first start result", data_bus, 12'h5A5);
    @(negedge clk);
    cs_n <= 1'b1; rd_n <= 1'b1;
    repeat (40) @(negedge clk);
    report();
  end
endmodule